// File: doc/BRIEF.md
# Bridge Bus Lock Controller

This block holds the exclusive-access state of a bridge that has one upstream serial-link port and two downstream parallel bus segments. It watches downstream requests that carry a lock attribute, along with the target-ready and abort status that each segment returns. It also watches for unlock messages arriving from upstream. From these it decides whether a segment is locked and which one. A single bit records the owning segment.

While a lock is held, the block does four things:

- It drives the lock pin of the owning segment on every downstream cycle to that segment.
- It answers inbound memory requests from that segment with retry.
- It stalls the inbound read-prefetch request stream. Read completions still pass through it.
- It flags the other segment and the internal interrupt controllers as blocked from forwarding.

A locked read that aborts releases the lock once its completion has gone upstream. An aborted write keeps the lock until the unlock message arrives. For every aborted downstream cycle, the block reports a one-byte abort index for the split-completion message.

The prefetch request path and the completion path are valid/ready streams. A beat moves on a cycle where both valid and ready are high.

- Prefetch path: while locked, the block holds `pf_out_valid` and `pf_in_ready` low. This stalls the source without losing a beat. While unlocked, valid passes forward and ready passes back with no delay.
- Completion path: this path is never gated. Ready follows the consumer in every state.

Top module: `bus_lock_ctrl`

## Requirements
- R1: After the synchronous active-high reset, no lock is held. `lock_out`, `ib_retry`, `seg_fwd_block`, `intc_block` and `abort_msg_valid` are all low, and the prefetch stream passes unchanged.
- R2: A lock is taken on segment s from the cycle after a downstream cycle with `ds_valid`, `ds_lock`, `ds_read` high, `ds_internal` low, `ds_seg`=s and `seg_trdy[s]` high.
- R3: No lock is taken by a locked write, or by a locked read whose target does not assert target-ready. A locked request with `ds_internal` high takes no lock either.
- R4: An `us_unlock` pulse releases a held lock from the next cycle.
- R5: While segment s is locked, `ib_retry[s]` equals `ib_valid[s] & ib_mem[s]`. `ib_retry` of the other segment stays low, and non-memory requests are never retried.
- R6: While locked, `pf_out_valid` and `pf_in_ready` are low. Otherwise `pf_out_valid`=`pf_in_valid` and `pf_in_ready`=`pf_out_ready`. The completion stream passes unchanged in every state.
- R7: While segment s is locked, `lock_out[s]` is high on every downstream cycle to s, whatever its `ds_lock`. While unlocked, `lock_out[s]` is high only for a cycle to s with `ds_lock` high and `ds_internal` low.
- R8: While segment s is locked, `seg_fwd_block` of the other segment and `intc_block` are high, and `seg_fwd_block[s]` is low.
- R9: A locked read to the owning segment that sees master or target abort keeps the lock until a `cpl_sent` pulse. The lock is released from the cycle after that pulse.
- R10: A write that aborts while locked does not release the lock, even if `cpl_sent` pulses. Only `us_unlock` releases it.
- R11: `ib_lock` has no effect on any output.
- R12: The cycle after any downstream cycle with an abort on its segment, `abort_msg_valid` is high and `abort_msg_idx` is 8'h00 for master abort and 8'h01 for target abort. Master abort wins when both are seen.
- R13: At most one segment is locked. A locked read to the other segment while a lock is held does not move the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ds_valid | input | 1 | Downstream cycle in progress |
| ds_seg | input | 1 | Target segment of the downstream cycle |
| ds_lock | input | 1 | Lock attribute of the downstream cycle |
| ds_read | input | 1 | Downstream cycle is a memory read (else write) |
| ds_internal | input | 1 | Downstream cycle targets an internal device |
| seg_trdy | input | 2 | Target-ready per segment |
| seg_mabort | input | 2 | Master abort per segment |
| seg_tabort | input | 2 | Target abort per segment |
| us_unlock | input | 1 | Unlock message received upstream (pulse) |
| cpl_sent | input | 1 | Completion for the current locked read sent upstream (pulse) |
| ib_valid | input | 2 | Inbound request present per segment |
| ib_mem | input | 2 | Inbound request is a memory transaction |
| ib_lock | input | 2 | Inbound lock attribute (ignored) |
| pf_in_valid | input | 1 | Prefetch request valid from engine |
| pf_in_ready | output | 1 | Prefetch request ready to engine |
| pf_out_valid | output | 1 | Prefetch request valid to upstream |
| pf_out_ready | input | 1 | Prefetch request ready from upstream |
| cpl_in_valid | input | 1 | Read completion valid from upstream |
| cpl_in_ready | output | 1 | Read completion ready to upstream |
| cpl_out_valid | output | 1 | Read completion valid to engine |
| cpl_out_ready | input | 1 | Read completion ready from engine |
| lock_out | output | 2 | Lock pin per segment, active high |
| ib_retry | output | 2 | Retry response per segment |
| seg_fwd_block | output | 2 | Forwarding blocked per segment |
| intc_block | output | 1 | Interrupt controller forwarding blocked |
| abort_msg_valid | output | 1 | Abort index valid |
| abort_msg_idx | output | 8 | Abort index: 00h master, 01h target |

## Verification
The bench targets the asymmetric exit, and it checks three faults there:

- A design that treats both abort kinds alike would drop the lock after an aborted write's completion.
- A design that releases early would drop the lock at the abort itself, before `cpl_sent`.
- A design that ignores the drain would keep the lock past it.

The bench also covers the paths that must not take a lock: a write, a read without target-ready, and an internal target. A naive design would start retrying there. Further checks cover the following:

- A locked read to the second segment must not steal ownership.
- Both abort flags seen together must report the master-abort index.
- Cycles to the owning segment without the lock attribute must still drive the lock pin.

// File: rtl/bus_lock_pkg.sv
package bus_lock_pkg;
  localparam int unsigned NSEG  = 2;
  localparam int unsigned IDX_W = 8;

  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_HELD  = 2'd1,
    LK_DRAIN = 2'd2
  } lk_state_t;

  localparam logic [IDX_W-1:0] IDX_MASTER = 8'h00;
  localparam logic [IDX_W-1:0] IDX_TARGET = 8'h01;
endpackage

// File: rtl/lock_fsm.sv
module lock_fsm
  import bus_lock_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ds_valid,
  input  logic            ds_seg,
  input  logic            ds_lock,
  input  logic            ds_read,
  input  logic            ds_internal,
  input  logic [NSEG-1:0] seg_trdy,
  input  logic [NSEG-1:0] seg_mabort,
  input  logic [NSEG-1:0] seg_tabort,
  input  logic            us_unlock,
  input  logic            cpl_sent,
  output logic            locked,
  output logic            owner
);
  lk_state_t state;
  logic      locked_rd, take, rd_abort;

  assign locked_rd = ds_valid && ds_lock && ds_read && !ds_internal;
  assign take      = locked_rd && seg_trdy[ds_seg];
  assign rd_abort  = locked_rd && (ds_seg == owner) &&
                     (seg_mabort[ds_seg] || seg_tabort[ds_seg]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LK_IDLE;
      owner <= 1'b0;
    end else begin
      case (state)
        LK_IDLE: if (!us_unlock && take) begin
          state <= LK_HELD;
          owner <= ds_seg;
        end
        LK_HELD: begin
          if (us_unlock)     state <= LK_IDLE;
          else if (rd_abort) state <= LK_DRAIN;
        end
        LK_DRAIN: if (us_unlock || cpl_sent) state <= LK_IDLE;
        default: state <= LK_IDLE;
      endcase
    end
  end

  assign locked = (state == LK_HELD) || (state == LK_DRAIN);

  // R2/R3: a lock only appears after a qualifying locked read to a ready target
  p_entry_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(ds_valid && ds_lock && ds_read && !ds_internal));
  // R4: unlock message always releases
  p_unlock_r4: assert property (@(posedge clk) disable iff (rst)
    us_unlock |=> !locked);
  // R13: owner is stable while the lock is held
  p_owner_r13: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> $stable(owner));
  // R10: write aborts never release the lock
  p_wr_abort_r10: assert property (@(posedge clk) disable iff (rst)
    (state == LK_HELD && ds_valid && !ds_read && !us_unlock) |=> locked);
endmodule

// File: rtl/abort_report.sv
module abort_report
  import bus_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ds_valid,
  input  logic             ds_seg,
  input  logic [NSEG-1:0]  seg_mabort,
  input  logic [NSEG-1:0]  seg_tabort,
  output logic             msg_valid,
  output logic [IDX_W-1:0] msg_idx
);
  logic mab, tab;
  assign mab = ds_valid && seg_mabort[ds_seg];
  assign tab = ds_valid && seg_tabort[ds_seg];

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_idx   <= IDX_MASTER;
    end else begin
      msg_valid <= mab || tab;
      if (mab)      msg_idx <= IDX_MASTER;
      else if (tab) msg_idx <= IDX_TARGET;
    end
  end

  // R12: an abort is always followed by a report
  p_report_r12: assert property (@(posedge clk) disable iff (rst)
    (mab || tab) |=> msg_valid);
  // R12: master abort takes priority
  p_master_r12: assert property (@(posedge clk) disable iff (rst)
    mab |=> (msg_idx == IDX_MASTER));
endmodule

// File: rtl/lock_gate.sv
module lock_gate
  import bus_lock_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            locked,
  input  logic            owner,
  input  logic            ds_valid,
  input  logic            ds_seg,
  input  logic            ds_lock,
  input  logic            ds_internal,
  input  logic [NSEG-1:0] ib_valid,
  input  logic [NSEG-1:0] ib_mem,
  input  logic            pf_in_valid,
  output logic            pf_in_ready,
  output logic            pf_out_valid,
  input  logic            pf_out_ready,
  input  logic            cpl_in_valid,
  output logic            cpl_in_ready,
  output logic            cpl_out_valid,
  input  logic            cpl_out_ready,
  output logic [NSEG-1:0] lock_out,
  output logic [NSEG-1:0] ib_retry,
  output logic [NSEG-1:0] seg_fwd_block,
  output logic            intc_block
);
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic own, to_seg;
    assign own    = locked && (owner == s[0]);
    assign to_seg = ds_valid && (ds_seg == s[0]);
    assign lock_out[s]      = to_seg && (own || (!locked && ds_lock && !ds_internal));
    assign ib_retry[s]      = own && ib_valid[s] && ib_mem[s];
    assign seg_fwd_block[s] = locked && !own;
  end

  assign intc_block    = locked;
  assign pf_out_valid  = pf_in_valid && !locked;
  assign pf_in_ready   = pf_out_ready && !locked;
  assign cpl_out_valid = cpl_in_valid;
  assign cpl_in_ready  = cpl_out_ready;

  // R5: only one segment can ever be retried
  p_retry_one_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ib_retry));
  // R8: owner is never blocked while the other segment is
  p_block_r8: assert property (@(posedge clk) disable iff (rst)
    locked |-> ($countones(seg_fwd_block) == 1) && intc_block);
  // R6: no prefetch beat moves while locked
  p_pf_r6: assert property (@(posedge clk) disable iff (rst)
    locked |-> !(pf_out_valid && pf_out_ready));
endmodule

// File: rtl/bus_lock_ctrl.sv
module bus_lock_ctrl
  import bus_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ds_valid,
  input  logic             ds_seg,
  input  logic             ds_lock,
  input  logic             ds_read,
  input  logic             ds_internal,
  input  logic [NSEG-1:0]  seg_trdy,
  input  logic [NSEG-1:0]  seg_mabort,
  input  logic [NSEG-1:0]  seg_tabort,
  input  logic             us_unlock,
  input  logic             cpl_sent,
  input  logic [NSEG-1:0]  ib_valid,
  input  logic [NSEG-1:0]  ib_mem,
  input  logic [NSEG-1:0]  ib_lock,
  input  logic             pf_in_valid,
  output logic             pf_in_ready,
  output logic             pf_out_valid,
  input  logic             pf_out_ready,
  input  logic             cpl_in_valid,
  output logic             cpl_in_ready,
  output logic             cpl_out_valid,
  input  logic             cpl_out_ready,
  output logic [NSEG-1:0]  lock_out,
  output logic [NSEG-1:0]  ib_retry,
  output logic [NSEG-1:0]  seg_fwd_block,
  output logic             intc_block,
  output logic             abort_msg_valid,
  output logic [IDX_W-1:0] abort_msg_idx
);
  logic locked, owner;
  // R11: inbound lock attribute deliberately has no effect
  logic unused_ib_lock;
  assign unused_ib_lock = ^ib_lock;

  lock_fsm u_fsm (
    .clk(clk), .rst(rst), .ds_valid(ds_valid), .ds_seg(ds_seg),
    .ds_lock(ds_lock), .ds_read(ds_read), .ds_internal(ds_internal),
    .seg_trdy(seg_trdy), .seg_mabort(seg_mabort), .seg_tabort(seg_tabort),
    .us_unlock(us_unlock), .cpl_sent(cpl_sent),
    .locked(locked), .owner(owner)
  );

  abort_report u_rpt (
    .clk(clk), .rst(rst), .ds_valid(ds_valid), .ds_seg(ds_seg),
    .seg_mabort(seg_mabort), .seg_tabort(seg_tabort),
    .msg_valid(abort_msg_valid), .msg_idx(abort_msg_idx)
  );

  lock_gate u_gate (
    .clk(clk), .rst(rst), .locked(locked), .owner(owner),
    .ds_valid(ds_valid), .ds_seg(ds_seg), .ds_lock(ds_lock),
    .ds_internal(ds_internal), .ib_valid(ib_valid), .ib_mem(ib_mem),
    .pf_in_valid(pf_in_valid), .pf_in_ready(pf_in_ready),
    .pf_out_valid(pf_out_valid), .pf_out_ready(pf_out_ready),
    .cpl_in_valid(cpl_in_valid), .cpl_in_ready(cpl_in_ready),
    .cpl_out_valid(cpl_out_valid), .cpl_out_ready(cpl_out_ready),
    .lock_out(lock_out), .ib_retry(ib_retry),
    .seg_fwd_block(seg_fwd_block), .intc_block(intc_block)
  );
endmodule

// File: tb/tb_bus_lock_ctrl.sv
module tb_bus_lock_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic ds_valid = 0, ds_seg = 0, ds_lock = 0, ds_read = 0, ds_internal = 0;
  logic [1:0] seg_trdy = 0, seg_mabort = 0, seg_tabort = 0;
  logic us_unlock = 0, cpl_sent = 0;
  logic [1:0] ib_valid = 0, ib_mem = 0, ib_lock = 0;
  logic pf_in_valid = 0, pf_out_ready = 0, cpl_in_valid = 0, cpl_out_ready = 0;
  logic pf_in_ready, pf_out_valid, cpl_in_ready, cpl_out_valid;
  logic [1:0] lock_out, ib_retry, seg_fwd_block;
  logic intc_block, abort_msg_valid;
  logic [7:0] abort_msg_idx;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_lock_ctrl dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_ds();
    ds_valid = 0; ds_lock = 0; ds_read = 0; ds_internal = 0;
    seg_trdy = 0; seg_mabort = 0; seg_tabort = 0; us_unlock = 0; cpl_sent = 0;
  endtask

  // inbound memory on both segments, then read retry (comb, after settle)
  task automatic probe_retry(input string req, input logic [1:0] exp);
    ib_valid = 2'b11; ib_mem = 2'b11; #1;
    chk(req, ib_retry, exp);
    ib_valid = 0; ib_mem = 0;
  endtask

  task automatic take_lock(input logic s);
    @(negedge clk);
    ds_valid = 1; ds_seg = s; ds_lock = 1; ds_read = 1; seg_trdy = 2'b00;
    seg_trdy[s] = 1'b1; #1;
    chk("R7 lock pin on establishing read", lock_out, (s ? 2'b10 : 2'b01));
    @(negedge clk); idle_ds();
  endtask

  task automatic unlock();
    @(negedge clk); us_unlock = 1;
    @(negedge clk); idle_ds();
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    probe_retry("R1 retry after reset", 2'b00);
    pf_in_valid = 1; pf_out_ready = 1; #1;
    chk("R1 prefetch passes", {pf_out_valid, pf_in_ready}, 2'b11);
    chk("R1 blocks clear", {seg_fwd_block, intc_block}, 3'b000);
    chk("R1 lock pins and msg", {lock_out, abort_msg_valid}, 3'b000);
    pf_in_valid = 0; pf_out_ready = 0;
  endtask

  task automatic t_no_entry();
    @(negedge clk); ds_valid = 1; ds_seg = 0; ds_lock = 1; ds_read = 0; seg_trdy = 2'b01;
    @(negedge clk); idle_ds(); probe_retry("R3 locked write takes no lock", 2'b00);
    @(negedge clk); ds_valid = 1; ds_seg = 1; ds_lock = 1; ds_read = 1; seg_trdy = 2'b00;
    @(negedge clk); idle_ds(); probe_retry("R3 no target-ready takes no lock", 2'b00);
    @(negedge clk); ds_valid = 1; ds_seg = 1; ds_lock = 1; ds_read = 1; ds_internal = 1;
    seg_trdy = 2'b10; #1;
    chk("R7 internal target no lock pin", lock_out, 2'b00);
    @(negedge clk); idle_ds(); probe_retry("R3 internal target takes no lock", 2'b00);
    ib_lock = 2'b11;
    @(negedge clk); probe_retry("R11 inbound lock attribute ignored", 2'b00);
    #1 chk("R11 no block from inbound lock", {seg_fwd_block, intc_block}, 3'b000);
    ib_lock = 0;
  endtask

  task automatic t_lock_seg1();
    take_lock(1'b1);
    probe_retry("R2 R5 retry on owner seg1 only", 2'b10);
    ib_valid = 2'b11; ib_mem = 2'b01; #1;
    chk("R5 non-memory not retried", ib_retry, 2'b00);
    ib_valid = 0; ib_mem = 0;
    chk("R8 other segment and intc blocked", {seg_fwd_block, intc_block}, 3'b011);
    pf_in_valid = 1; pf_out_ready = 1; cpl_in_valid = 1; cpl_out_ready = 1; #1;
    chk("R6 prefetch stalled", {pf_out_valid, pf_in_ready}, 2'b00);
    chk("R6 completions pass", {cpl_out_valid, cpl_in_ready}, 2'b11);
    pf_in_valid = 0; pf_out_ready = 0; cpl_in_valid = 0; cpl_out_ready = 0;
    ds_valid = 1; ds_seg = 1; ds_lock = 0; #1;
    chk("R7 lock pin on unlocked-attribute cycle", lock_out, 2'b10);
    ds_seg = 0; #1;
    chk("R7 no pin on other segment", lock_out, 2'b00);
    // R13: locked read with target-ready on seg0 while seg1 holds the lock
    ds_lock = 1; ds_read = 1; seg_trdy = 2'b01;
    @(negedge clk); idle_ds();
    probe_retry("R13 owner unchanged", 2'b10);
    unlock();
    probe_retry("R4 unlock releases", 2'b00);
    #1 chk("R4 blocks released", {seg_fwd_block, intc_block}, 3'b000);
  endtask

  task automatic t_read_abort();
    take_lock(1'b0);
    ds_valid = 1; ds_seg = 0; ds_lock = 1; ds_read = 1; seg_mabort = 2'b01;
    @(negedge clk); idle_ds();
    chk("R12 master abort index", {abort_msg_valid, abort_msg_idx}, {1'b1, 8'h00});
    probe_retry("R9 lock held before completion", 2'b01);
    repeat (3) @(negedge clk);
    probe_retry("R9 lock held while draining", 2'b01);
    cpl_sent = 1;
    @(negedge clk); idle_ds();
    probe_retry("R9 released after completion", 2'b00);
  endtask

  task automatic t_write_abort();
    take_lock(1'b0);
    ds_valid = 1; ds_seg = 0; ds_lock = 0; ds_read = 0; seg_tabort = 2'b01;
    @(negedge clk); idle_ds();
    chk("R12 target abort index", {abort_msg_valid, abort_msg_idx}, {1'b1, 8'h01});
    cpl_sent = 1;
    @(negedge clk); idle_ds();
    probe_retry("R10 write abort keeps lock", 2'b01);
    @(negedge clk);
    probe_retry("R10 still locked", 2'b01);
    unlock();
    probe_retry("R10 released by unlock", 2'b00);
  endtask

  task automatic t_both_abort();
    @(negedge clk);
    ds_valid = 1; ds_seg = 1; ds_read = 0; seg_mabort = 2'b10; seg_tabort = 2'b10;
    @(negedge clk); idle_ds();
    chk("R12 master wins", {abort_msg_valid, abort_msg_idx}, {1'b1, 8'h00});
    @(negedge clk);
    chk("R12 report is one cycle", abort_msg_valid, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_no_entry();
        t_lock_seg1();
        t_read_abort();
        t_write_abort();
        t_both_abort();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule